// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the bookkeeping half of a receive DMA for an Ethernet port. A small local store holds a ring of descriptors, and each descriptor is four 32-bit words: a status word, a size/count word, a buffer address and a link to the next descriptor. Software fills each descriptor, hands it to the engine by setting the ownership bit, and starts the engine with a command write. Each completed frame fills the current descriptor with the received length and hands it back to software. The engine then follows the link to the next descriptor. Payload movement and CRC checking are handled elsewhere. The engine sees only the frame length, which arrives on a valid/ready handshake when the frame ends.

If the engine reaches a descriptor that software still owns, the frame is dropped and counted, and the engine stops. It stays stopped until software writes the start command again. While the engine is stopped, `frm_ready` is low and the frame source must hold its frame. A frame transfers on a clock edge where `frm_valid` and `frm_ready` are both high. The source must not change `frm_len` while `frm_valid` is high and `frm_ready` is low.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset every descriptor word reads 0, the first and current pointers read 0, the engine is stopped, `overrun_cnt` is 0 and `rx_done` is low.
- R2: A CPU write to the command register with bit 7 set starts the engine. A command write with bit 7 clear leaves the engine state unchanged. Reading the command register returns the run state in bit 7.
- R3: `frm_ready` is high exactly while the engine is running. A frame offered while the engine is stopped is neither consumed nor counted.
- R4: A frame accepted on a descriptor whose status bit 31 is 1 (engine-owned) makes these changes to that descriptor. Bits [15:0] of its size/count word become min(length, bits [31:16]), and bits [31:16] keep their value. Status bit 31 becomes 0.
- R5: When the frame length exceeds the buffer size in bits [31:16], status bit 15 becomes 1; otherwise it becomes 0. Status bits other than 31 and 15 keep their values.
- R6: After each completion the current pointer takes the low index bits of that descriptor's next word.
- R7: `rx_done` is high for exactly the one cycle after each completion, and low at all other times.
- R8: A frame accepted on a descriptor whose status bit 31 is 0 leaves every descriptor word unchanged and leaves the current pointer unchanged. It adds 1 to `overrun_cnt`, which counts modulo 2^OVR_W, and it stops the engine.
- R9: When a start command lands in the same cycle as a drop, the engine stays running and the drop is still counted.
- R10: If a CPU write targets the status word or the size/count word of the descriptor being completed in that same cycle, the engine's value is kept. In that same cycle, CPU writes to other words take effect.
- R11: Address map. When the top address bit is 0, the CPU addresses descriptor `addr[IDX_W+1:2]`, word `addr[1:0]` (0 status, 1 size/count, 2 buffer, 3 next). When the top bit is 1, word 0 is the command register, word 1 is the first pointer and word 2 is the current pointer. A write to the first pointer loads both the first and current pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | End-of-frame strobe; a length is offered |
| frm_ready | output | 1 | Engine will take the offered frame (high while running) |
| frm_len | input | 16 | Received frame length in bytes |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | IDX_W+3 | CPU word address (see R11) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, combinational from `cpu_addr` |
| rx_done | output | 1 | One-cycle pulse per descriptor returned to the CPU |
| overrun_cnt | output | OVR_W | Count of frames dropped on CPU-owned descriptors |
| running | output | 1 | Engine run state |

## Verification
Two pairs of actions can land in one clock cycle. A completion can coincide with a CPU write to the same descriptor, and a drop on a CPU-owned descriptor can coincide with a start command. The bench provokes both by driving `frm_valid` and `cpu_wr` in the same cycle. It then checks that the engine's status and count values survive while a buffer-word write in that cycle still lands. It also checks that the engine stays running and that the drop is still counted. These checks sit inside a length sweep over descriptors of different buffer sizes, and the expected count and truncation flag for each frame are computed from its length and buffer size.

// File: rtl/rx_desc_pkg.sv
package rx_desc_pkg;
  localparam int WORD_W         = 32;
  localparam int CNT_W          = 16;
  localparam int WORDS_PER_DESC = 4;
  localparam int OWN_BIT        = 31;
  localparam int TRUNC_BIT      = 15;
  localparam int START_BIT      = 7;
  // descriptor word slots
  localparam int W_STAT = 0;
  localparam int W_SIZE = 1;
  localparam int W_BUF  = 2;
  localparam int W_NEXT = 3;
  // control register slots
  localparam int C_CMD   = 0;
  localparam int C_FIRST = 1;
  localparam int C_CUR   = 2;
  localparam logic [WORD_W-1:0] OWN_MASK   = WORD_W'(1) << OWN_BIT;
  localparam logic [WORD_W-1:0] TRUNC_MASK = WORD_W'(1) << TRUNC_BIT;
  localparam logic [WORD_W-1:0] KEEP_MASK  = ~(OWN_MASK | TRUNC_MASK);
endpackage

// File: rtl/rx_desc_ram.sv
module rx_desc_ram
  import rx_desc_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [1:0]        cpu_word,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [WORD_W-1:0] eng_stat,
  input  logic [WORD_W-1:0] eng_size,
  output logic [WORD_W-1:0] eng_stat_q,
  output logic [CNT_W-1:0]  eng_bufsz_q,
  output logic [IDX_W-1:0]  eng_next_q
);
  localparam int SLOTS = NUM_DESC * WORDS_PER_DESC;

  logic [WORD_W-1:0] slot_q [SLOTS];

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    for (genvar w = 0; w < WORDS_PER_DESC; w++) begin : g_word
      localparam bit ENG_OWNS = (w == W_STAT) || (w == W_SIZE);
      logic              eng_hit;
      logic              cpu_hit;
      logic [WORD_W-1:0] eng_val;
      logic [WORD_W-1:0] word_q;

      assign eng_hit = ENG_OWNS && eng_we && (eng_idx == IDX_W'(d));
      assign cpu_hit = cpu_we && (cpu_idx == IDX_W'(d)) && (cpu_word == 2'(w));
      assign eng_val = (w == W_STAT) ? eng_stat : eng_size;

      // engine write-back has priority over a colliding CPU write
      always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (eng_hit) word_q <= eng_val;
        else if (cpu_hit) word_q <= cpu_wdata;
      end

      assign slot_q[d*WORDS_PER_DESC + w] = word_q;
    end
  end

  assign cpu_rdata   = slot_q[{cpu_idx, cpu_word}];
  assign eng_stat_q  = slot_q[{eng_idx, 2'(W_STAT)}];
  assign eng_bufsz_q = slot_q[{eng_idx, 2'(W_SIZE)}][WORD_W-1:CNT_W];
  assign eng_next_q  = slot_q[{eng_idx, 2'(W_NEXT)}][IDX_W-1:0];
endmodule

// File: rtl/rx_desc_fill.sv
module rx_desc_fill
  import rx_desc_pkg::*;
(
  input  logic [WORD_W-1:0] stat_in,
  input  logic [CNT_W-1:0]  buf_sz,
  input  logic [CNT_W-1:0]  frm_len,
  output logic [WORD_W-1:0] stat_out,
  output logic [WORD_W-1:0] size_out
);
  logic             trunc;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    trunc    = frm_len > buf_sz;
    cnt      = trunc ? buf_sz : frm_len;
    size_out = {buf_sz, cnt};
    stat_out = (stat_in & KEEP_MASK) | (trunc ? TRUNC_MASK : '0);
  end
endmodule

// File: rtl/rx_desc_ctrl.sv
module rx_desc_ctrl #(
  parameter int IDX_W = 2,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             frm_valid,
  input  logic             cur_owned,
  input  logic [IDX_W-1:0] next_idx,
  input  logic             ld_first,
  input  logic             ld_cur,
  input  logic [IDX_W-1:0] ptr_wval,
  output logic             running,
  output logic             frm_ready,
  output logic             complete,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] first_idx,
  output logic             rx_done,
  output logic [OVR_W-1:0] overrun_cnt
);
  logic drop;

  assign frm_ready = running;
  assign complete  = frm_valid && running && cur_owned;
  assign drop      = frm_valid && running && !cur_owned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      cur_idx     <= '0;
      first_idx   <= '0;
      rx_done     <= 1'b0;
      overrun_cnt <= '0;
    end else begin
      if (start_cmd)  running <= 1'b1;
      else if (drop)  running <= 1'b0;

      if (complete)             cur_idx <= next_idx;
      else if (ld_cur || ld_first) cur_idx <= ptr_wval;

      if (ld_first) first_idx <= ptr_wval;

      rx_done <= complete;
      if (drop) overrun_cnt <= overrun_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rx_desc_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int OVR_W    = 8,
  parameter int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [CNT_W-1:0]  frm_len,
  input  logic              cpu_wr,
  input  logic [IDX_W+2:0]  cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              rx_done,
  output logic [OVR_W-1:0]  overrun_cnt,
  output logic              running
);
  logic              cpu_ctl;
  logic [IDX_W-1:0]  cpu_idx;
  logic [1:0]        cpu_word;
  logic              desc_we, ctl_we;
  logic              start_cmd, ld_first, ld_cur;
  logic              complete, cur_owned;
  logic [IDX_W-1:0]  cur_idx, first_idx, next_idx;
  logic [WORD_W-1:0] stat_q, stat_new, size_new, ram_rdata;
  logic [CNT_W-1:0]  bufsz_q;

  assign cpu_ctl   = cpu_addr[IDX_W+2];
  assign cpu_idx   = cpu_addr[IDX_W+1:2];
  assign cpu_word  = cpu_addr[1:0];
  assign desc_we   = cpu_wr && !cpu_ctl;
  assign ctl_we    = cpu_wr && cpu_ctl;
  assign start_cmd = ctl_we && (cpu_word == 2'(C_CMD)) && cpu_wdata[START_BIT];
  assign ld_first  = ctl_we && (cpu_word == 2'(C_FIRST));
  assign ld_cur    = ctl_we && (cpu_word == 2'(C_CUR));
  assign cur_owned = stat_q[OWN_BIT];

  rx_desc_ram #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_ram (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_we      (desc_we),
    .cpu_idx     (cpu_idx),
    .cpu_word    (cpu_word),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (ram_rdata),
    .eng_we      (complete),
    .eng_idx     (cur_idx),
    .eng_stat    (stat_new),
    .eng_size    (size_new),
    .eng_stat_q  (stat_q),
    .eng_bufsz_q (bufsz_q),
    .eng_next_q  (next_idx)
  );

  rx_desc_fill u_fill (
    .stat_in  (stat_q),
    .buf_sz   (bufsz_q),
    .frm_len  (frm_len),
    .stat_out (stat_new),
    .size_out (size_new)
  );

  rx_desc_ctrl #(.IDX_W(IDX_W), .OVR_W(OVR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cmd   (start_cmd),
    .frm_valid   (frm_valid),
    .cur_owned   (cur_owned),
    .next_idx    (next_idx),
    .ld_first    (ld_first),
    .ld_cur      (ld_cur),
    .ptr_wval    (cpu_wdata[IDX_W-1:0]),
    .running     (running),
    .frm_ready   (frm_ready),
    .complete    (complete),
    .cur_idx     (cur_idx),
    .first_idx   (first_idx),
    .rx_done     (rx_done),
    .overrun_cnt (overrun_cnt)
  );

  always_comb begin
    cpu_rdata = ram_rdata;
    if (cpu_ctl) begin
      unique case (cpu_word)
        2'(C_CMD):   cpu_rdata = WORD_W'({running, 7'b0});
        2'(C_FIRST): cpu_rdata = WORD_W'(first_idx);
        2'(C_CUR):   cpu_rdata = WORD_W'(cur_idx);
        default:     cpu_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
  parameter int IDX_W = 2,
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             running,
  input logic             rx_done,
  input logic [OVR_W-1:0] overrun_cnt,
  input logic             start_cmd,
  input logic             cur_owned,
  input logic [IDX_W-1:0] next_idx,
  input logic [IDX_W-1:0] cur_idx
);
  logic take;
  assign take = frm_valid && frm_ready;

  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (running && frm_ready));

  p_ready_after_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cur_owned && !start_cmd) |=> !frm_ready);

  p_cur_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_owned) |=> (cur_idx == $past(next_idx)));

  p_done_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_owned) |=> rx_done);

  p_done_only_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && cur_owned) |=> !rx_done);

  p_overrun_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cur_owned) |=> ((overrun_cnt - $past(overrun_cnt)) == OVR_W'(1)));

  p_overrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && !cur_owned) |=> $stable(overrun_cnt));

  p_start_beats_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cur_owned && start_cmd) |=> running);
endmodule

bind rx_desc_ring rx_desc_ring_chk #(.IDX_W(IDX_W), .OVR_W(OVR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_valid   (frm_valid),
  .frm_ready   (frm_ready),
  .running     (running),
  .rx_done     (rx_done),
  .overrun_cnt (overrun_cnt),
  .start_cmd   (start_cmd),
  .cur_owned   (cur_owned),
  .next_idx    (next_idx),
  .cur_idx     (cur_idx)
);

// File: tb/tb_rx_desc_ring.sv
`timescale 1ns/1ps
module tb_rx_desc_ring;
  localparam int ND = 4;
  localparam int IW = 2;
  localparam int OW = 8;
  localparam int CTL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [15:0] frm_len = '0;
  logic        cpu_wr = 1'b0;
  logic [IW+2:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        rx_done;
  logic [OW-1:0] overrun_cnt;
  logic        running;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int exp_next [ND];
  int cur_e;
  int ovr_e;

  always #10 clk = ~clk;

  rx_desc_ring #(.NUM_DESC(ND), .OVR_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rx_done(rx_done), .overrun_cnt(overrun_cnt), .running(running)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] arm_val(input int d);
    return 32'h8000_0000 | (32'(d) << 20) | 32'(d + 1);
  endfunction

  function automatic int size_of(input int d);
    case (d)
      0: return 1536;
      1: return 100;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int len_of(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 1535;
      3: return 1536;
      4: return 1537;
      5: return 65535;
      6: return 99;
      7: return 100;
      default: return (k * 173) % 1700;
    endcase
  endfunction

  function automatic logic [31:0] filled(input logic [31:0] st, input int len, input int sz);
    return (st & ~32'h8000_8000) | ((len > sz) ? 32'h0000_8000 : 32'h0);
  endfunction

  task automatic cpu_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = (IW+3)'(addr); cpu_wdata = data;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input int addr, output logic [31:0] data);
    cpu_addr = (IW+3)'(addr);
    #1;
    data = cpu_rdata;
  endtask

  task automatic send_frame(input int len);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'(len);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic arm(input int d);
    cpu_write(d*4 + 0, arm_val(d));
    cpu_write(d*4 + 1, 32'(size_of(d)) << 16);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic [31:0] st_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 running", 32'(running), 0);
    chk("R1 overrun", 32'(overrun_cnt), 0);
    chk("R1 rx_done", 32'(rx_done), 0);
    for (int a = 0; a < ND*4; a++) begin
      cpu_read(a, rd);
      chk("R1 desc word", rd, 0);
    end
    cpu_read(CTL+1, rd); chk("R1 first ptr", rd, 0);
    cpu_read(CTL+2, rd); chk("R1 cur ptr", rd, 0);
    chk("R3 ready while stopped", 32'(frm_ready), 0);

    // build ring
    for (int d = 0; d < ND; d++) begin
      arm(d);
      cpu_write(d*4 + 2, 32'h1000 * d);
      cpu_write(d*4 + 3, 32'((d + 1) % ND));
      exp_next[d] = (d + 1) % ND;
    end
    cpu_read(2*4 + 3, rd); chk("R11 next word map", rd, 3);

    // R2: command without bit 7
    cpu_write(CTL, 32'h0000_007F);
    chk("R2 no start without bit7", 32'(running), 0);
    cpu_write(CTL, 32'h0000_0080);
    chk("R2 start", 32'(running), 1);
    chk("R3 ready while running", 32'(frm_ready), 1);
    cpu_read(CTL, rd); chk("R2 cmd readback", rd, 32'h80);

    // length sweep over descriptors of different buffer sizes
    cur_e = 0;
    ovr_e = 0;
    for (int k = 0; k < 48; k++) begin
      int d;
      int len;
      int sz;
      d = cur_e; len = len_of(k); sz = size_of(d);
      send_frame(len);
      chk("R7 rx_done pulse", 32'(rx_done), 1);
      cpu_read(d*4 + 0, rd); chk("R4/R5 status", rd, filled(arm_val(d), len, sz));
      cpu_read(d*4 + 1, rd);
      chk("R4 size/count", rd, (32'(sz) << 16) | 32'((len > sz) ? sz : len));
      cpu_read(CTL+2, rd); chk("R6 cur follows next", rd, 32'(exp_next[d]));
      cur_e = exp_next[d];
      @(negedge clk);
      chk("R7 rx_done one cycle", 32'(rx_done), 0);
      arm(d);
      if (k == 23) begin
        cpu_write(1*4 + 3, 32'd3);
        exp_next[1] = 3;
      end
    end
    chk("R8 no overrun in sweep", 32'(overrun_cnt), 0);

    // R8: hit a CPU-owned descriptor
    cpu_write(cur_e*4 + 0, 32'h0000_0000);
    cpu_read(cur_e*4 + 1, st_before);
    send_frame(77);
    chk("R7 no done on drop", 32'(rx_done), 0);
    chk("R8 overrun +1", 32'(overrun_cnt), 1);
    chk("R8 stopped", 32'(running), 0);
    chk("R3 ready low after drop", 32'(frm_ready), 0);
    cpu_read(cur_e*4 + 0, rd); chk("R8 status untouched", rd, 0);
    cpu_read(cur_e*4 + 1, rd); chk("R8 size untouched", rd, st_before);
    cpu_read(CTL+2, rd); chk("R8 cur unchanged", rd, 32'(cur_e));
    // R3: offered while stopped, not consumed
    @(negedge clk); frm_valid = 1'b1; frm_len = 16'd5;
    repeat (3) @(negedge clk);
    frm_valid = 1'b0;
    chk("R3 stopped frames ignored", 32'(overrun_cnt), 1);
    chk("R3 no done while stopped", 32'(rx_done), 0);

    cpu_write(CTL, 32'h80);
    send_frame(10);
    chk("R8 second drop", 32'(overrun_cnt), 2);
    chk("R8 stopped again", 32'(running), 0);

    // R9: start in the same cycle as a drop
    cpu_write(CTL, 32'h80);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'd20;
    cpu_wr = 1'b1; cpu_addr = (IW+3)'(CTL); cpu_wdata = 32'h80;
    @(negedge clk);
    frm_valid = 1'b0; cpu_wr = 1'b0;
    chk("R9 still running", 32'(running), 1);
    chk("R9 drop counted", 32'(overrun_cnt), 3);
    send_frame(20);
    chk("R9 later drop stops", 32'(running), 0);
    chk("R9 later drop counted", 32'(overrun_cnt), 4);
    ovr_e = 4;

    // R10: collision on the status word
    arm(cur_e);
    cpu_write(CTL, 32'h80);
    begin
      int d;
      d = cur_e;
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 16'd50;
      cpu_wr = 1'b1; cpu_addr = (IW+3)'(d*4); cpu_wdata = 32'h8000_00FF;
      @(negedge clk);
      frm_valid = 1'b0; cpu_wr = 1'b0;
      chk("R10 done on collision", 32'(rx_done), 1);
      cpu_read(d*4, rd); chk("R10 engine status wins", rd, filled(arm_val(d), 50, size_of(d)));
      cur_e = exp_next[d];
    end
    // R10: collision with the buffer word
    begin
      int d;
      d = cur_e;
      arm(d);
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 16'd40;
      cpu_wr = 1'b1; cpu_addr = (IW+3)'(d*4 + 2); cpu_wdata = 32'hABCD_0000;
      @(negedge clk);
      frm_valid = 1'b0; cpu_wr = 1'b0;
      cpu_read(d*4 + 2, rd); chk("R10 buffer word written", rd, 32'hABCD_0000);
      cpu_read(d*4, rd); chk("R10 status filled", rd, filled(arm_val(d), 40, size_of(d)));
      cpu_read(d*4 + 1, rd);
      chk("R10 count filled", rd, (32'(size_of(d)) << 16) | 32'((40 > size_of(d)) ? size_of(d) : 40));
      cur_e = exp_next[d];
    end

    // R8: counter wraps
    cpu_write(cur_e*4, 32'h0);
    while (ovr_e != 0) begin
      cpu_write(CTL, 32'h80);
      send_frame(1);
      ovr_e = (ovr_e + 1) % (1 << OW);
    end
    chk("R8 overrun wraps", 32'(overrun_cnt), 0);
    chk("R8 stopped after wrap", 32'(running), 0);

    // R11: first pointer loads both pointers
    cpu_write(CTL+1, 32'd2);
    cpu_read(CTL+1, rd); chk("R11 first ptr", rd, 2);
    cpu_read(CTL+2, rd); chk("R11 cur loaded", rd, 2);
    arm(2);
    cpu_write(CTL, 32'h80);
    send_frame(5);
    chk("R11 done at new base", 32'(rx_done), 1);
    cpu_read(2*4, rd); chk("R5 truncated at base", rd, filled(arm_val(2), 5, 1));
    cpu_read(2*4 + 1, rd); chk("R4 count clipped", rd, 32'h0001_0001);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule